// File: doc/BRIEF.md
# Transmit-Only Display-ID Serial Streamer

This block sends the full contents of a 128 x 8 identification memory out on a serial data line, paced by a dedicated slow clock input (VCLK). It takes no commands from a host. While the mode-enable input is high, every rising edge of VCLK moves the stream on by one step. The first nine edges after entry keep the line released. From then on each edge presents one bit, most significant bit first. Each byte is followed by a one-bit released (high) gap, so a byte takes nine edges. The first byte sent comes from the top address (127). Address 0 follows it, and the address count wraps from 127 back to 0 for as long as VCLK runs.

VCLK is sampled by the system clock `clk`. A rising edge takes effect at the first `clk` edge that sees VCLK high, with no further pipeline stage. The memory is read combinationally through `mem_addr`/`mem_data`. The serial output is an open-drain style pair: when `sda_oe` is high the line carries `sda_o`, and when it is low the line is released and pulled high. When the enable input drops, the output is released on the next clock. The block also rewinds, so the next entry starts again with the blanking period and address 127.

Top module: `ddc_txo_streamer`

## Requirements
- R1: After reset, and whenever `txo_en` is low, `sda_oe` is 0 and `mem_addr` is 127. A VCLK that is already high at reset or at entry does not count as a rising edge.
- R2: For the first nine VCLK rising edges after `txo_en` goes high, `sda_oe` stays 0.
- R3: From the tenth rising edge on, each edge in a byte sets `sda_oe` to 1 and `sda_o` to one data bit, bit 7 first and bit 0 last, taken from `mem_data` at `mem_addr`.
- R4: The edge after bit 0 of every byte outputs a null bit by setting `sda_oe` to 0, giving a frame of nine edges per byte.
- R5: The first byte after entry comes from address 127, and the following bytes come from addresses 0, 1, 2 and so on. `mem_addr` steps by one on each null-bit edge.
- R6: After address 127 the pointer wraps to 0 and streaming continues without a gap.
- R7: The outputs change at the first `clk` edge that samples VCLK high after it was low, and stay unchanged at all other `clk` edges.
- R8: When `txo_en` is deasserted, `sda_oe` goes to 0 and `mem_addr` to 127 at the next clock edge. A later entry restarts with the nine-edge blanking period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples VCLK |
| rst | input | 1 | Synchronous active-high reset |
| txo_en | input | 1 | Transmit-only mode active |
| vclk | input | 1 | Stream pacing clock, acted on at its rising edges |
| mem_addr | output | 7 | Memory read address |
| mem_data | input | 8 | Memory read data for `mem_addr`, combinational |
| sda_oe | output | 1 | Serial line drive enable (0 = released, reads high) |
| sda_o | output | 1 | Serial line value while driven |

## Verification
A behavioural model counts VCLK edges since entry and predicts the line state and address on every clock. VCLK is driven with uneven high and low lengths, and with levels held over many clocks, which separates true edge detection from level sensing and exposes output movement between edges. A run of more than 128 frames over a memory whose bytes differ reaches the 127-to-0 wrap and confirms the bit order and address order. Dropping the enable in mid-frame and re-entering while VCLK is already high shows that the block rewinds to blanking and address 127, and that a high level at entry is not taken as an edge.

// File: rtl/ddc_txo_pkg.sv
package ddc_txo_pkg;

    localparam int ADDR_W_DEF = 7;
    localparam int DATA_W_DEF = 8;
    localparam int BLANK_DEF  = 9;

    typedef enum logic [1:0] {
        ACT_BLANK = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SHIFT = 2'd2,
        ACT_NULL  = 2'd3
    } txo_act_e;

    typedef struct packed {
        logic     step;
        txo_act_e act;
    } txo_step_t;

    function automatic txo_act_e pick_act(logic blanking, logic first_bit, logic null_bit);
        if (blanking)
            return ACT_BLANK;
        else if (first_bit)
            return ACT_LOAD;
        else if (null_bit)
            return ACT_NULL;
        else
            return ACT_SHIFT;
    endfunction

endpackage

// File: rtl/txo_vclk_edge.sv
module txo_vclk_edge (
    input  logic clk,
    input  logic rst,
    input  logic vclk,
    output logic rise
);
    logic vclk_q;

    always_ff @(posedge clk) begin
        if (rst)
            vclk_q <= 1'b1;
        else
            vclk_q <= vclk;
    end

    assign rise = vclk & ~vclk_q;

endmodule

// File: rtl/txo_frame_seq.sv
module txo_frame_seq
    import ddc_txo_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int BLANK  = BLANK_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      rise,
    output txo_step_t step
);
    localparam int BC_W = $clog2(BLANK + 1);
    localparam int BI_W = $clog2(DATA_W + 1);
    localparam logic [BC_W-1:0] BLANK_V = BC_W'(BLANK);
    localparam logic [BI_W-1:0] NULL_V  = BI_W'(DATA_W);

    logic [BC_W-1:0] blank_cnt;
    logic [BI_W-1:0] bit_idx;
    logic            blanking;

    assign blanking  = blank_cnt < BLANK_V;
    assign step.step = en & rise;
    assign step.act  = pick_act(blanking, bit_idx == '0, bit_idx == NULL_V);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            blank_cnt <= '0;
            bit_idx   <= '0;
        end else if (rise) begin
            case (step.act)
                ACT_BLANK: blank_cnt <= blank_cnt + 1'b1;
                ACT_NULL:  bit_idx   <= '0;
                default:   bit_idx   <= bit_idx + 1'b1;
            endcase
        end
    end

    // R2: blanking count never passes its limit
    a_r2_blank_bound: assert property (@(posedge clk) disable iff (rst)
        blank_cnt <= BLANK_V);

    // R4: bit position stays inside the nine-step frame
    a_r4_frame_bound: assert property (@(posedge clk) disable iff (rst)
        bit_idx <= NULL_V);

    // R8: leaving the mode rewinds the sequencer
    a_r8_seq_rewind: assert property (@(posedge clk) disable iff (rst)
        !en |=> (blank_cnt == '0 && bit_idx == '0));

endmodule

// File: rtl/txo_shift_out.sv
module txo_shift_out
    import ddc_txo_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  txo_step_t         step,
    input  logic [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              sda_oe,
    output logic              sda_o
);
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            mem_addr <= '1;
            shreg    <= '0;
            sda_oe   <= 1'b0;
            sda_o    <= 1'b0;
        end else if (step.step) begin
            case (step.act)
                ACT_BLANK: sda_oe <= 1'b0;
                ACT_LOAD: begin
                    sda_oe <= 1'b1;
                    sda_o  <= mem_data[DATA_W-1];
                    shreg  <= mem_data << 1;
                end
                ACT_SHIFT: begin
                    sda_o <= shreg[DATA_W-1];
                    shreg <= shreg << 1;
                end
                ACT_NULL: begin
                    sda_oe   <= 1'b0;
                    mem_addr <= mem_addr + 1'b1;
                end
                default: sda_oe <= 1'b0;
            endcase
        end
    end

    // R3: the first bit of a byte is the top bit of the memory word
    a_r3_msb_first: assert property (@(posedge clk) disable iff (rst)
        (en && step.step && step.act == ACT_LOAD) |=>
            (sda_oe && sda_o == $past(mem_data[DATA_W-1])));

    // R4: the null step releases the line
    a_r4_null_release: assert property (@(posedge clk) disable iff (rst)
        (en && step.step && step.act == ACT_NULL) |=> !sda_oe);

    // R6: the pointer wraps from the top address to zero
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (en && step.step && step.act == ACT_NULL && mem_addr == '1) |=> (mem_addr == '0));

    // R7: no movement between VCLK edges
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (en && !step.step) |=> ($stable(sda_oe) && $stable(sda_o) && $stable(mem_addr)));

    // R8: leaving the mode releases the line and rewinds the pointer
    a_r8_exit_release: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!sda_oe && mem_addr == '1));

endmodule

// File: rtl/ddc_txo_streamer.sv
module ddc_txo_streamer
    import ddc_txo_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int BLANK  = BLANK_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txo_en,
    input  logic              vclk,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data,
    output logic              sda_oe,
    output logic              sda_o
);
    logic      rise;
    txo_step_t step;

    txo_vclk_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .vclk (vclk),
        .rise (rise)
    );

    txo_frame_seq #(
        .DATA_W (DATA_W),
        .BLANK  (BLANK)
    ) u_seq (
        .clk  (clk),
        .rst  (rst),
        .en   (txo_en),
        .rise (rise),
        .step (step)
    );

    txo_shift_out #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .en       (txo_en),
        .step     (step),
        .mem_data (mem_data),
        .mem_addr (mem_addr),
        .sda_oe   (sda_oe),
        .sda_o    (sda_o)
    );

endmodule

// File: tb/ddc_txo_streamer_tb.sv
`timescale 1ns/1ps
module ddc_txo_streamer_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       txo_en;
    logic       vclk;
    logic [6:0] mem_addr;
    logic [7:0] mem_data;
    logic       sda_oe;
    logic       sda_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mval(input int a);
        return 8'((a * 29 + 7) ^ 8'h5A);
    endfunction

    assign mem_data = mval(int'(mem_addr));

    ddc_txo_streamer u_dut (
        .clk      (clk),
        .rst      (rst),
        .txo_en   (txo_en),
        .vclk     (vclk),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .sda_oe   (sda_oe),
        .sda_o    (sda_o)
    );

    // behavioural model: edges counted since entry
    int   pc = 0;
    int   last_pc = 0;
    logic vprev = 1'b1;
    logic seen_en = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            pc = 0;
            vprev = 1'b1;
        end else begin
            if (!txo_en)
                pc = 0;
            else if (vclk && !vprev)
                pc = pc + 1;
            vprev = vclk;
            if (txo_en) seen_en = 1'b1;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (edge %0d)", tag, what, act, exp, pc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            int    k, frame, pos, n, eaddr;
            string tag;
            logic  eoe, eo;
            eoe = 1'b0; eo = 1'b0; n = 0;
            if (pc == 0) begin
                tag = seen_en ? "R8" : "R1";
            end else if (pc <= 9) begin
                tag = "R2";
            end else begin
                k = pc - 10;
                frame = k / 9;
                pos = k % 9;
                n = (k + 1) / 9;
                if (pos < 8) begin
                    eoe = 1'b1;
                    eo = mval((127 + frame) % 128)[7 - pos];
                    tag = (frame == 0) ? "R5" : (frame >= 128 ? "R6" : "R3");
                end else begin
                    tag = "R4";
                end
            end
            if (pc == last_pc && pc > 0) tag = "R7";
            eaddr = (127 + n) % 128;
            check(tag, "sda_oe", int'(sda_oe), int'(eoe));
            if (eoe) check(tag, "sda_o", int'(sda_o), int'(eo));
            check((n >= 129) ? "R6" : (pc == 0 ? tag : "R5"), "mem_addr", int'(mem_addr), eaddr);
            last_pc = pc;
        end
    end

    task automatic pulse(input int hi, input int lo);
        @(negedge clk) vclk = 1'b1;
        repeat (hi - 1) @(negedge clk);
        @(negedge clk) vclk = 1'b0;
        repeat (lo - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; txo_en = 1'b0; vclk = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: edges while disabled leave the block idle
        for (int i = 0; i < 5; i++) pulse(2, 2);
        // R2..R6: long run over the wrap, uneven VCLK shape
        @(negedge clk) txo_en = 1'b1;
        for (int i = 0; i < 9; i++) pulse(1 + (i % 2), 1 + (i % 3));
        for (int i = 0; i < 1200; i++) pulse(1 + (i % 3), 1 + ((i / 3) % 2));
        // R7: long static levels
        pulse(12, 15);
        for (int i = 0; i < 4; i++) pulse(1, 1);
        // R8: exit mid-frame, then enter with VCLK already high
        @(negedge clk) txo_en = 1'b0;
        for (int i = 0; i < 3; i++) pulse(2, 1);
        @(negedge clk) vclk = 1'b1;
        @(negedge clk) txo_en = 1'b1;
        repeat (3) @(negedge clk);
        @(negedge clk) vclk = 1'b0;
        for (int i = 0; i < 40; i++) pulse(2, 3);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule